// File: doc/BRIEF.md
# Queued SPI Master

The block is an SPI master driven through a small 32-bit register port. Software pushes command words into a four-entry transmit queue. Each word holds a data frame and its own control bits: which chip selects to drive, whether chip select stays asserted after the frame, whether the frame ends a queue, and whether the frame counter restarts. The block shifts each frame out on SCK/MOSI, captures MISO into a four-entry receive FIFO and keeps status flags and one interrupt line.

One attribute register sets the frame length (1 to 16 bits), the clock polarity and phase, the bit order and the SCK rate. Frames run only while the halt bit in the configuration register is clear. Software usually pushes up to four words, marks the last one as end of queue, waits for the end-of-queue flag or interrupt and then drains the receive FIFO.

Top module: `qspi_master`

## Requirements
- R1: Writing offset 0x10 queues a command word: data in bits 15:0, chip-select pattern in 21:16, counter-clear in 26, end-of-queue in 27, hold-select in 31. The queue holds 4 words. A push while it is full is discarded. Status bit 25 reads 1 while the queue is not full.
- R2: Configuration offset 0x00 bit 0 is the halt bit and resets to 1. While it is set no frame starts. Once it is clear, queued words are sent in push order.
- R3: Frame length is attribute (offset 0x04) bits 30:27 plus one. Data bits above the length are not sent. Bit 24 set sends the LSB first, clear sends the MSB first. Each received frame enters the RX FIFO right-aligned. Reading offset 0x14 returns the oldest entry in bits 15:0 and removes it. Status bit 17 reads 1 while the RX FIFO holds data.
- R4: Attribute bit 26 is the SCK idle level. With bit 25 clear, MISO is sampled on the first edge of each bit. With bit 25 set, it is sampled on the second edge. A frame of N bits makes exactly 2N SCK edges.
- R5: The SCK half period is P*S/2 system clocks. P comes from attribute bits 17:16 (0..3 give 2, 3, 5, 7). S comes from the scaler code C in bits 3:0: 2(C+1) for C<3, else 2^C.
- R6: During a frame, pcs_o equals the idle-level field (configuration bits 21:16, reset 0x3F) XOR the word's pattern. After a frame with bit 31 clear, pcs_o returns to the idle levels.
- R7: After a frame with bit 31 set, the selects stay asserted until the next frame. This also holds when the queue runs empty; SCK then rests at its idle level.
- R8: Status bit 31 sets when any frame ends. Status bit 28 sets when a frame pushed with bit 27 ends. Writing 1 to either bit clears only that bit.
- R9: irq_o is high exactly while status bit 28 and interrupt-enable (offset 0x0C) bit 28 are both set.
- R10: Count offset 0x18 bits 31:16 hold a 16-bit frame counter. It increments when each frame ends. A frame pushed with bit 26 set leaves it at 1. It resets to 0.
- R11: Writing configuration with bit 11 set empties the transmit queue. Writing with bit 10 set empties the RX FIFO. Neither bit is stored.
- R12: No frame starts while the RX FIFO is full. A pending word starts after one entry is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops RX at offset 0x14) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from address |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| pcs_o | output | 6 | Chip-select lines |
| irq_o | output | 1 | End-of-queue interrupt |

## Verification
The bench loops MOSI back to MISO and watches the wire. It records each bit at the sampling edge, so a reversed bit order or a wrong sampling edge shows up as a wrong captured word even when the looped-back data still matches. It fills the queue past four with the end-of-queue marker on the discarded fifth word; a design that accepted the overflow would raise the end-of-queue flag. It leaves the RX FIFO full with a word pending, which a design that did not stall would send and lose. It also counts chip-select release events across held and non-held frames, which exposes a design that drops select between held frames or keeps it after an unheld one.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  localparam int unsigned FRAME_W = 16;
  localparam int unsigned CS_W    = 6;
  localparam int unsigned HALF_W  = 18;

  typedef struct packed {
    logic              hold;
    logic              eoq;
    logic              clr;
    logic [CS_W-1:0]   cs;
    logic [FRAME_W-1:0] data;
  } cmd_t;

  localparam logic [7:0] A_CFG  = 8'h00;
  localparam logic [7:0] A_ATTR = 8'h04;
  localparam logic [7:0] A_STAT = 8'h08;
  localparam logic [7:0] A_IEN  = 8'h0C;
  localparam logic [7:0] A_PUSH = 8'h10;
  localparam logic [7:0] A_POP  = 8'h14;
  localparam logic [7:0] A_CNT  = 8'h18;

  // half SCK period in system clocks
  function automatic logic [HALF_W-1:0] half_cycles(input logic [1:0] pre, input logic [3:0] scl);
    logic [2:0]  p;
    logic [14:0] s;
    case (pre)
      2'd0:    p = 3'd2;
      2'd1:    p = 3'd3;
      2'd2:    p = 3'd5;
      default: p = 3'd7;
    endcase
    if (scl < 4'd3) s = 15'(scl) + 15'd1;
    else            s = 15'd1 << (scl - 4'd1);
    return HALF_W'(p) * HALF_W'(s);
  endfunction
endpackage

// File: rtl/qspi_fifo.sv
module qspi_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign full_o  = (cnt == (AW+1)'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (flush_i) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem[wp] <= data_i;
  end

  // R1
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> full_o);
endmodule

// File: rtl/qspi_shift.sv
module qspi_shift
  import qspi_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] data_i,
  input  logic [3:0]         fsz_i,
  input  logic               cpol_i,
  input  logic               cpha_i,
  input  logic               lsbf_i,
  input  logic [HALF_W-1:0]  half_i,
  input  logic               miso_i,
  output logic               sck_o,
  output logic               mosi_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] rx_o
);
  logic               busy, done, tog, pol, pha, lsb;
  logic [HALF_W-1:0]  tmr, hlf;
  logic [5:0]         step, edges;
  logic [3:0]         fsz;
  logic [FRAME_W-1:0] tsr, rsr;
  logic               tick, lead, smp, shf;

  assign edges = ({2'b00, fsz} + 6'd1) << 1;
  assign tick  = busy && (tmr == '0);
  assign lead  = ~step[0];
  assign smp   = pha ? ~lead : lead;
  assign shf   = pha ? (lead && step != 6'd0) : (!lead && step != edges - 6'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy <= 1'b0; done <= 1'b0; tog <= 1'b0;
      pol <= 1'b0; pha <= 1'b0; lsb <= 1'b0;
      tmr <= '0; hlf <= '0; step <= '0; fsz <= '0;
      tsr <= '0; rsr <= '0;
    end else begin
      done <= 1'b0;
      if (start_i && !busy) begin
        busy <= 1'b1; tog <= 1'b0; step <= '0; rsr <= '0;
        hlf <= half_i; tmr <= half_i - HALF_W'(1);
        fsz <= fsz_i; pol <= cpol_i; pha <= cpha_i; lsb <= lsbf_i;
        tsr <= lsbf_i ? data_i : (data_i << (4'd15 - fsz_i));
      end else if (tick) begin
        tmr <= hlf - HALF_W'(1);
        if (step < edges) begin
          tog  <= ~tog;
          step <= step + 6'd1;
          if (smp) rsr <= lsb ? {miso_i, rsr[FRAME_W-1:1]} : {rsr[FRAME_W-2:0], miso_i};
          if (shf) tsr <= lsb ? (tsr >> 1) : (tsr << 1);
        end else begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (busy) begin
        tmr <= tmr - HALF_W'(1);
      end
    end
  end

  assign sck_o  = busy ? (pol ^ tog) : cpol_i;
  assign mosi_o = lsb ? tsr[0] : tsr[FRAME_W-1];
  assign busy_o = busy;
  assign done_o = done;
  assign rx_o   = lsb ? (rsr >> (4'd15 - fsz)) : rsr;

  // R4
  sck_home_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> ($past(sck_o) == pol));
  // R4
  step_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (step <= edges));
endmodule

// File: rtl/qspi_master.sv
module qspi_master
  import qspi_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 4,
  parameter int unsigned RX_DEPTH = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  reg_addr_i,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        sck_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic [5:0]  pcs_o,
  output logic        irq_o
);
  localparam int unsigned CMD_W = $bits(cmd_t);

  logic            cfg_halt;
  logic [CS_W-1:0] cfg_idle;
  logic [3:0]      at_fsz, at_scl;
  logic            at_cpol, at_cpha, at_lsb;
  logic [1:0]      at_pre;
  logic            ien_eoq, st_tcf, st_eoq;
  logic [15:0]     xfer_cnt;
  logic [CS_W-1:0] cs_sel;
  cmd_t            cur, push_cmd, tx_q;
  logic [FRAME_W-1:0] rx_q, eng_rx;
  logic            tx_full, tx_empty, rx_full, rx_empty;
  logic            eng_busy, eng_done, start;
  logic            wr_cfg, wr_attr, wr_stat, wr_ien, wr_push, rd_pop;

  assign wr_cfg  = reg_wr_i && reg_addr_i == A_CFG;
  assign wr_attr = reg_wr_i && reg_addr_i == A_ATTR;
  assign wr_stat = reg_wr_i && reg_addr_i == A_STAT;
  assign wr_ien  = reg_wr_i && reg_addr_i == A_IEN;
  assign wr_push = reg_wr_i && reg_addr_i == A_PUSH;
  assign rd_pop  = reg_rd_i && reg_addr_i == A_POP;

  assign push_cmd = '{hold: reg_wdata_i[31], eoq: reg_wdata_i[27], clr: reg_wdata_i[26],
                      cs: reg_wdata_i[21:16], data: reg_wdata_i[15:0]};

  assign start = !cfg_halt && !tx_empty && !eng_busy && !eng_done && !rx_full;

  qspi_fifo #(.W(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk_i, .rst_ni, .flush_i(wr_cfg && reg_wdata_i[11]),
    .push_i(wr_push), .data_i(push_cmd), .pop_i(start),
    .data_o(tx_q), .full_o(tx_full), .empty_o(tx_empty));

  qspi_fifo #(.W(FRAME_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk_i, .rst_ni, .flush_i(wr_cfg && reg_wdata_i[10]),
    .push_i(eng_done), .data_i(eng_rx), .pop_i(rd_pop),
    .data_o(rx_q), .full_o(rx_full), .empty_o(rx_empty));

  qspi_shift u_shift (
    .clk_i, .rst_ni, .start_i(start), .data_i(tx_q.data), .fsz_i(at_fsz),
    .cpol_i(at_cpol), .cpha_i(at_cpha), .lsbf_i(at_lsb),
    .half_i(half_cycles(at_pre, at_scl)), .miso_i,
    .sck_o, .mosi_o, .busy_o(eng_busy), .done_o(eng_done), .rx_o(eng_rx));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_halt <= 1'b1; cfg_idle <= '1;
      at_fsz <= 4'd7; at_cpol <= 1'b0; at_cpha <= 1'b0; at_lsb <= 1'b0;
      at_pre <= '0; at_scl <= '0;
      ien_eoq <= 1'b0; st_tcf <= 1'b0; st_eoq <= 1'b0;
      xfer_cnt <= '0; cs_sel <= '0; cur <= '0;
    end else begin
      if (wr_cfg) begin
        cfg_halt <= reg_wdata_i[0];
        cfg_idle <= reg_wdata_i[21:16];
      end
      if (wr_attr) begin
        at_fsz <= reg_wdata_i[30:27]; at_cpol <= reg_wdata_i[26];
        at_cpha <= reg_wdata_i[25];   at_lsb <= reg_wdata_i[24];
        at_pre <= reg_wdata_i[17:16]; at_scl <= reg_wdata_i[3:0];
      end
      if (wr_ien) ien_eoq <= reg_wdata_i[28];
      if (start) begin
        cur    <= tx_q;
        cs_sel <= tx_q.cs;
      end else if (eng_done && !cur.hold) begin
        cs_sel <= '0;
      end
      if (eng_done)                      st_tcf <= 1'b1;
      else if (wr_stat && reg_wdata_i[31]) st_tcf <= 1'b0;
      if (eng_done && cur.eoq)           st_eoq <= 1'b1;
      else if (wr_stat && reg_wdata_i[28]) st_eoq <= 1'b0;
      if (eng_done) xfer_cnt <= cur.clr ? 16'd1 : xfer_cnt + 16'd1;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      A_CFG:   reg_rdata_o = {10'b0, cfg_idle, 15'b0, cfg_halt};
      A_ATTR:  reg_rdata_o = {1'b0, at_fsz, at_cpol, at_cpha, at_lsb, 6'b0, at_pre, 12'b0, at_scl};
      A_STAT:  reg_rdata_o = {st_tcf, 2'b0, st_eoq, 2'b0, !tx_full, 7'b0, !rx_empty, 17'b0};
      A_IEN:   reg_rdata_o = {3'b0, ien_eoq, 28'b0};
      A_POP:   reg_rdata_o = {16'b0, rx_q};
      A_CNT:   reg_rdata_o = {xfer_cnt, 16'b0};
      default: reg_rdata_o = '0;
    endcase
  end

  assign pcs_o = cfg_idle ^ cs_sel;
  assign irq_o = st_eoq && ien_eoq;

  // R2
  halt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_halt && !eng_busy) |=> !eng_busy);
  // R12
  rx_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full && !eng_busy) |=> !eng_busy);
  // R8
  eoq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done && cur.eoq) |=> st_eoq);
  // R7
  cs_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done && cur.hold) |=> (cs_sel == $past(cs_sel)));
  // R6
  cs_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done && !cur.hold && !wr_cfg) |=> (pcs_o == cfg_idle));
endmodule

// File: tb/qspi_master_tb.sv
module qspi_master_tb;
  import qspi_pkg::*;

  localparam int unsigned CLK_NS = 10;
  localparam int unsigned NV = 6;
  localparam logic [31:0] V_ATTR [NV] = '{32'h38000000, 32'h3D030000, 32'h7A010001,
                                          32'h1F020003, 32'h59000004, 32'h02000000};
  localparam logic [15:0] V_DATA [NV] = '{16'h0096, 16'h002C, 16'hBEEF,
                                          16'h00F9, 16'h05A3, 16'h0001};
  localparam logic [31:0] RUN  = 32'h003F0000;
  localparam logic [31:0] HOLD = 32'h003F0001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        sck, mosi, irq;
  logic [5:0]  pcs;

  always #(CLK_NS/2) clk = ~clk;

  qspi_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sck_o(sck), .mosi_o(mosi),
    .miso_i(mosi), .pcs_o(pcs), .irq_o(irq));

  // wire monitor
  logic        mon_cpol = 1'b0, mon_cpha = 1'b0;
  logic        sck_prev = 1'b0;
  logic [5:0]  pcs_prev = 6'h3F;
  logic [15:0] cap = '0;
  logic [5:0]  cs_at_edge = '0;
  int          edge_cnt = 0, rel_cnt = 0, cyc = 0, last_edge = 0, half_last = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    sck_prev <= sck;
    pcs_prev <= pcs;
    if (pcs_prev != 6'h3F && pcs == 6'h3F) rel_cnt <= rel_cnt + 1;
    if (sck != sck_prev && pcs != 6'h3F) begin
      edge_cnt  <= edge_cnt + 1;
      half_last <= cyc - last_edge;
      last_edge <= cyc;
      if (((sck != mon_cpol) && !mon_cpha) || ((sck == mon_cpol) && mon_cpha)) begin
        cap <= {cap[14:0], mosi};
        cs_at_edge <= pcs;
      end
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_eoq(input string req);
    logic [31:0] s = '0;
    bit ok = 1'b0;
    for (int k = 0; k < 4000 && !ok; k++) begin
      rd_reg(A_STAT, s);
      ok = s[28];
    end
    chk(req, 32'(ok), 32'd1);
  endtask

  function automatic logic [15:0] rev_bits(input logic [15:0] d, input int n);
    logic [15:0] r = '0;
    for (int k = 0; k < n; k++) r[k] = d[n-1-k];
    return r;
  endfunction

  function automatic int exp_half(input logic [1:0] pre, input logic [3:0] c);
    int p, s;
    p = (pre == 0) ? 2 : (pre == 1) ? 3 : (pre == 2) ? 5 : 7;
    s = (c < 3) ? 2 * (c + 1) : (1 << c);
    return p * s / 2;
  endfunction

  initial begin
    #(CLK_NS * 180000);
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks + 1, fails + 1);
    $finish;
  end

  initial begin
    logic [31:0] v, s;
    int e0, r0, n;
    logic [15:0] mask;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd_reg(A_CFG, v);  chk("R2 reset cfg", v, 32'h003F0001);
    rd_reg(A_STAT, v); chk("R1 reset status", v, 32'h02000000);
    rd_reg(A_ATTR, v); chk("R3 reset attr", v, 32'h38000000);
    rd_reg(A_CNT, v);  chk("R10 reset count", v, 32'h0);
    chk("R6 reset pcs", 32'(pcs), 32'h3F);
    chk("R9 reset irq", 32'(irq), 32'h0);

    // table-driven frames
    wr_reg(A_CFG, RUN);
    for (int i = 0; i < NV; i++) begin
      n = int'(V_ATTR[i][30:27]) + 1;
      mask = 16'((32'd1 << n) - 1);
      wr_reg(A_ATTR, V_ATTR[i]);
      mon_cpol = V_ATTR[i][26];
      mon_cpha = V_ATTR[i][25];
      e0 = edge_cnt;
      wr_reg(A_PUSH, {4'b0000, 1'b1, (i == 0), 4'b0, 6'(1 << (i % 6)), V_DATA[i]});
      wait_eoq("R8 eoq flag");
      rd_reg(A_POP, v);
      chk("R3 rx word", v, {16'b0, V_DATA[i] & mask});
      chk("R3 bit order", {16'b0, cap & mask},
          {16'b0, V_ATTR[i][24] ? rev_bits(V_DATA[i], n) : (V_DATA[i] & mask)});
      chk("R4 edge count", 32'(edge_cnt - e0), 32'(2 * n));
      chk("R5 half period", 32'(half_last), 32'(exp_half(V_ATTR[i][17:16], V_ATTR[i][3:0])));
      chk("R4 sck idle", 32'(sck), 32'(mon_cpol));
      chk("R6 pcs in frame", 32'(cs_at_edge), 32'(6'h3F ^ 6'(1 << (i % 6))));
      chk("R6 pcs after", 32'(pcs), 32'h3F);
      rd_reg(A_STAT, v); chk("R8 status", v, 32'h92000000);
      wr_reg(A_STAT, 32'h90000000);
    end
    rd_reg(A_CNT, v); chk("R10 count after table", v, 32'h00060000);

    // overflow, halt, rx stall
    wr_reg(A_ATTR, 32'h38000000); mon_cpol = 1'b0; mon_cpha = 1'b0;
    wr_reg(A_CFG, HOLD);
    e0 = edge_cnt;
    wr_reg(A_PUSH, 32'h04010011);
    wr_reg(A_PUSH, 32'h00010022);
    wr_reg(A_PUSH, 32'h00010033);
    wr_reg(A_PUSH, 32'h00010044);
    rd_reg(A_STAT, v); chk("R1 full flag", 32'(v[25]), 32'h0);
    wr_reg(A_PUSH, 32'h08010055);
    repeat (100) @(negedge clk);
    chk("R2 halted no edges", 32'(edge_cnt - e0), 32'h0);
    wr_reg(A_CFG, RUN);
    repeat (400) @(negedge clk);
    rd_reg(A_STAT, v); chk("R1 fifth push dropped", v & 32'h90000000, 32'h80000000);
    rd_reg(A_CNT, v);  chk("R10 clear then count", v, 32'h00040000);
    e0 = edge_cnt;
    wr_reg(A_PUSH, 32'h08010066);
    repeat (200) @(negedge clk);
    chk("R12 stall on rx full", 32'(edge_cnt - e0), 32'h0);
    rd_reg(A_POP, v); chk("R2 order 1", v, 32'h11);
    wait_eoq("R12 resumes after pop");
    rd_reg(A_POP, v); chk("R2 order 2", v, 32'h22);
    rd_reg(A_POP, v); chk("R2 order 3", v, 32'h33);
    rd_reg(A_POP, v); chk("R2 order 4", v, 32'h44);
    rd_reg(A_POP, v); chk("R12 pending word", v, 32'h66);
    rd_reg(A_STAT, v); chk("R3 rx empty flag", 32'(v[17]), 32'h0);
    wr_reg(A_STAT, 32'h90000000);

    // flushes
    wr_reg(A_CFG, HOLD);
    wr_reg(A_PUSH, 32'h08010001);
    wr_reg(A_PUSH, 32'h08010002);
    wr_reg(A_CFG, HOLD | 32'h800);
    e0 = edge_cnt;
    wr_reg(A_CFG, RUN);
    repeat (200) @(negedge clk);
    chk("R11 tx flush no edges", 32'(edge_cnt - e0), 32'h0);
    rd_reg(A_STAT, v); chk("R11 tx flush no frame", 32'(v[31]), 32'h0);
    wr_reg(A_PUSH, 32'h08010003);
    wait_eoq("R11 frame before rx flush");
    rd_reg(A_STAT, v); chk("R3 rx data flag", 32'(v[17]), 32'h1);
    wr_reg(A_CFG, RUN | 32'h400);
    rd_reg(A_STAT, v); chk("R11 rx flush", 32'(v[17]), 32'h0);
    wr_reg(A_STAT, 32'h90000000);

    // held chip select
    r0 = rel_cnt;
    wr_reg(A_PUSH, 32'h8004003C);
    repeat (100) @(negedge clk);
    chk("R7 held after empty queue", 32'(pcs), 32'h3B);
    chk("R7 sck idle while held", 32'(sck), 32'h0);
    wr_reg(A_PUSH, 32'h80040011);
    wr_reg(A_PUSH, 32'h0804005A);
    wait_eoq("R7 held run");
    chk("R7 one release", 32'(rel_cnt - r0), 32'h1);
    chk("R6 idle after run", 32'(pcs), 32'h3F);
    wr_reg(A_CFG, RUN | 32'h400);
    wr_reg(A_STAT, 32'h90000000);
    r0 = rel_cnt;
    wr_reg(A_PUSH, 32'h00040001);
    wr_reg(A_PUSH, 32'h08040002);
    wait_eoq("R6 unheld run");
    chk("R6 release per frame", 32'(rel_cnt - r0), 32'h2);
    wr_reg(A_CFG, RUN | 32'h400);
    wr_reg(A_STAT, 32'h90000000);

    // interrupt and write-one-to-clear
    wr_reg(A_IEN, 32'h10000000);
    wr_reg(A_PUSH, 32'h08040077);
    wait_eoq("R9 frame");
    chk("R9 irq high", 32'(irq), 32'h1);
    wr_reg(A_STAT, 32'h10000000);
    chk("R9 irq low", 32'(irq), 32'h0);
    rd_reg(A_STAT, s); chk("R8 selective clear", s, 32'h82020000);

    // counter clear
    wr_reg(A_PUSH, 32'h0C040001);
    wait_eoq("R10 clear frame");
    rd_reg(A_CNT, v); chk("R10 cleared to one", v, 32'h00010000);
    wr_reg(A_STAT, 32'h90000000);
    wr_reg(A_PUSH, 32'h08040002);
    wait_eoq("R10 next frame");
    rd_reg(A_CNT, v); chk("R10 increments", v, 32'h00020000);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule